// File: doc/BRIEF.md
# Signature Stability and Jaccard Evaluator

This block sits behind a memory-based physical unclonable function and processes the raw bit signatures the array produces. Signatures reach it as a stream of fixed-width words, each tagged with a group number, a trial number and an operating mode. The block counts the words itself, so a signature is simply the next `SIG_BITS/WORD_W` accepted words.

In enrollment mode, each candidate group is read out `N_TRIALS` times. The block sends trial 0 of every group out through a write port to an external reference store. For every later trial, it reads back the matching trial-0 word and counts the bits that changed. When a group finishes its last trial, the block reports that group's flip total. It also keeps track of the most stable group seen so far, which is the one with the fewest flips.

In evaluation mode, the block reads the golden word for the tagged group through the same port. It accumulates the number of positions that read one in both signatures (the intersection) and in either signature (the union). A sequential divider then turns the two counts into the Jaccard index, given as an unsigned fixed-point value with one integer bit.

Top module: `sig_eval`

## Requirements
- R1: While reset is asserted, `jac_valid`, `done_valid` and `sel_valid` are low, and `jac_ratio`, `jac_inter` and `jac_union` are zero.
- R2: After an evaluation signature, `jac_inter` equals the number of bit positions that are one in both the fresh signature and the golden signature of that group.
- R3: After an evaluation signature, `jac_union` equals the number of bit positions that are one in at least one of the two signatures.
- R4: `jac_ratio` equals floor(inter × 2^FRAC_W / union), with bit FRAC_W as the integer bit. `jac_valid` pulses for exactly one cycle. It is visible after the FRAC_W-th rising edge following the edge that accepts the final word of the signature.
- R5: When the union is zero, `jac_ratio` is 2^FRAC_W (a similarity of 1.0) and `jac_empty` is high. Otherwise `jac_empty` is low.
- R6: The reference port has two uses. In enrollment, for trial 0 only, `ref_wr` is high and `ref_wdata` equals the word. In every other case `ref_wr` is low. In both modes, `ref_addr` equals group × 2^ceil(log2(SIG_BITS/WORD_W)) + word index.
- R7: For trials 1 to N_TRIALS-1, each bit that differs from the trial-0 word at the same address adds one to the flip total of that group. `done_valid` pulses after the edge that accepts the final word of trial N_TRIALS-1. With it, `done_group` and `done_flips` show that group and its total.
- R8: `sel_group` and `sel_flips` name the completed group with the smallest total. A group that ties the current best does not replace it. `sel_valid` rises together with the first `done_valid` pulse.
- R9: The first word of trial 0 of a group restarts that group's flip total from zero.
- R10: Words in enrollment mode leave the Jaccard outputs unchanged.
- R11: The first word of trial 0 of group 0 clears `sel_valid`, which restarts the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | A stream word is present this cycle |
| s_mode | input | 1 | 0 = enrollment, 1 = evaluation |
| s_group | input | clog2(N_GROUPS) | Candidate or challenge group |
| s_trial | input | clog2(N_TRIALS) | Trial number within the group |
| s_word | input | WORD_W | Signature word |
| ref_wr | output | 1 | Write trial-0 word to the reference store |
| ref_addr | output | clog2(N_GROUPS)+clog2(SIG_BITS/WORD_W) | Reference store word address |
| ref_wdata | output | WORD_W | Word to store |
| ref_rdata | input | WORD_W | Stored word at `ref_addr`, same cycle |
| jac_valid | output | 1 | Similarity result pulse |
| jac_ratio | output | FRAC_W+1 | Jaccard index, 1.FRAC_W unsigned |
| jac_inter | output | clog2(SIG_BITS+1) | Intersection count |
| jac_union | output | clog2(SIG_BITS+1) | Union count |
| jac_empty | output | 1 | Union was zero |
| done_valid | output | 1 | A group finished its last trial |
| done_group | output | clog2(N_GROUPS) | Group that finished |
| done_flips | output | clog2(SIG_BITS*(N_TRIALS-1)+1) | Its flip total |
| sel_valid | output | 1 | A selection is held |
| sel_group | output | clog2(N_GROUPS) | Most stable group so far |
| sel_flips | output | clog2(SIG_BITS*(N_TRIALS-1)+1) | Its flip total |

## Verification
The checks rest on several assumptions about the inputs:
- The group tag is always below N_GROUPS.
- The reference store returns, within the same cycle, the word last written at that address.
- Once an evaluation signature has ended, the next one does not end until the divider has published its result.
- Enrollment words do not arrive during that divider window.

The stimulus respects all of these. It waits more than FRAC_W idle cycles after each evaluation signature, it uses only legal group numbers, and it models the reference store as an array that is written on `ref_wr` and read combinationally. Within those limits the stimulus covers:
- a gap in the middle of a signature;
- tied flip totals;
- re-enrolling a group;
- identical, complementary, partly overlapping and all-zero signatures.

// File: rtl/sig_eval_pkg.sv
package sig_eval_pkg;
  typedef enum logic {
    MODE_ENROLL = 1'b0,
    MODE_EVAL   = 1'b1
  } sig_mode_e;
endpackage

// File: rtl/sig_word_pop.sv
module sig_word_pop #(
  parameter int W  = 64,
  parameter int PW = $clog2(W + 1)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [PW-1:0] n_and,
  output logic [PW-1:0] n_or,
  output logic [PW-1:0] n_xor
);
  always_comb begin
    n_and = '0;
    n_or  = '0;
    n_xor = '0;
    for (int i = 0; i < W; i++) begin
      n_and = n_and + PW'(a[i] & b[i]);
      n_or  = n_or  + PW'(a[i] | b[i]);
      n_xor = n_xor + PW'(a[i] ^ b[i]);
    end
  end
endmodule

// File: rtl/sig_frac_div.sv
module sig_frac_div #(
  parameter int CW = 17,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] num,
  input  logic [CW-1:0] den,
  output logic          res_valid,
  output logic [FW:0]   res_ratio,
  output logic [CW-1:0] res_num,
  output logic [CW-1:0] res_den,
  output logic          res_empty
);
  localparam int KW = $clog2(FW + 1);

  logic [KW-1:0] k_q, k_nx;
  logic [CW:0]   rem_q, rem_nx, rem_sh, rem_step;
  logic [CW-1:0] den_q, den_nx, num_q, num_nx;
  logic          full_q, full_nx, ge;
  logic [FW-1:0] quo_q, quo_nx, quo_step;
  logic          publish;

  always_comb begin
    rem_sh   = rem_q << 1;
    ge       = rem_sh >= {1'b0, den_q};
    rem_step = ge ? rem_sh - {1'b0, den_q} : rem_sh;
    quo_step = {quo_q[FW-2:0], ge};
    publish  = (k_q == KW'(1));
    k_nx = k_q; rem_nx = rem_q; den_nx = den_q; num_nx = num_q;
    full_nx = full_q; quo_nx = quo_q;
    if (start) begin
      k_nx    = KW'(FW);
      rem_nx  = {1'b0, num};
      den_nx  = den;
      num_nx  = num;
      full_nx = (num == den);
    end else if (k_q != '0) begin
      k_nx   = k_q - KW'(1);
      rem_nx = rem_step;
      quo_nx = quo_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= '0; rem_q <= '0; den_q <= '0; num_q <= '0;
      full_q <= 1'b0; quo_q <= '0;
    end else begin
      k_q <= k_nx; rem_q <= rem_nx; den_q <= den_nx; num_q <= num_nx;
      full_q <= full_nx; quo_q <= quo_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ratio <= '0;
      res_num   <= '0;
      res_den   <= '0;
      res_empty <= 1'b0;
    end else begin
      res_valid <= publish;
      if (publish) begin
        res_ratio <= full_q ? {1'b1, {FW{1'b0}}} : {1'b0, quo_step};
        res_num   <= num_q;
        res_den   <= den_q;
        res_empty <= (den_q == '0);
      end
    end
  end
endmodule

// File: rtl/sig_flip_select.sv
module sig_flip_select #(
  parameter int NG = 8,
  parameter int NT = 100,
  parameter int FLW = 23,
  parameter int PW = 7,
  parameter int GW = $clog2(NG),
  parameter int TW = $clog2(NT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           first,
  input  logic           last,
  input  logic [GW-1:0]  group,
  input  logic [TW-1:0]  trial,
  input  logic [PW-1:0]  xpop,
  output logic           done_valid,
  output logic [GW-1:0]  done_group,
  output logic [FLW-1:0] done_flips,
  output logic           sel_valid,
  output logic [GW-1:0]  sel_group,
  output logic [FLW-1:0] sel_flips
);
  logic [FLW-1:0] tot_q [NG];
  logic [FLW-1:0] sum;
  logic           fin, better, clr, t0;

  always_comb begin
    t0     = (trial == '0);
    sum    = ((t0 && first) ? '0 : tot_q[group]) + (t0 ? '0 : FLW'(xpop));
    fin    = en && last && (trial == TW'(NT - 1));
    clr    = en && first && t0 && (group == '0);
    better = !sel_valid || (sum < sel_flips);
  end

  for (genvar g = 0; g < NG; g++) begin : g_tot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          tot_q[g] <= '0;
      else if (en && (group == GW'(g)))    tot_q[g] <= sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid <= 1'b0; done_group <= '0; done_flips <= '0;
      sel_valid  <= 1'b0; sel_group  <= '0; sel_flips  <= '0;
    end else begin
      done_valid <= fin;
      if (fin) begin
        done_group <= group;
        done_flips <= sum;
      end
      if (clr) sel_valid <= 1'b0;
      else if (fin && better) begin
        sel_valid <= 1'b1;
        sel_group <= group;
        sel_flips <= sum;
      end
    end
  end
endmodule

// File: rtl/sig_eval.sv
module sig_eval
  import sig_eval_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int SIG_BITS = 65536,
  parameter int N_TRIALS = 100,
  parameter int N_GROUPS = 8,
  parameter int FRAC_W   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic s_mode,
  input  logic [$clog2(N_GROUPS)-1:0] s_group,
  input  logic [$clog2(N_TRIALS)-1:0] s_trial,
  input  logic [WORD_W-1:0] s_word,
  output logic ref_wr,
  output logic [$clog2(N_GROUPS)+$clog2(SIG_BITS/WORD_W)-1:0] ref_addr,
  output logic [WORD_W-1:0] ref_wdata,
  input  logic [WORD_W-1:0] ref_rdata,
  output logic jac_valid,
  output logic [FRAC_W:0] jac_ratio,
  output logic [$clog2(SIG_BITS+1)-1:0] jac_inter,
  output logic [$clog2(SIG_BITS+1)-1:0] jac_union,
  output logic jac_empty,
  output logic done_valid,
  output logic [$clog2(N_GROUPS)-1:0] done_group,
  output logic [$clog2(SIG_BITS*(N_TRIALS-1)+1)-1:0] done_flips,
  output logic sel_valid,
  output logic [$clog2(N_GROUPS)-1:0] sel_group,
  output logic [$clog2(SIG_BITS*(N_TRIALS-1)+1)-1:0] sel_flips
);
  localparam int N_WORDS = SIG_BITS / WORD_W;
  localparam int XW  = $clog2(N_WORDS);
  localparam int GW  = $clog2(N_GROUPS);
  localparam int TW  = $clog2(N_TRIALS);
  localparam int CW  = $clog2(SIG_BITS + 1);
  localparam int PW  = $clog2(WORD_W + 1);
  localparam int FLW = $clog2(SIG_BITS * (N_TRIALS - 1) + 1);

  logic [XW-1:0] widx_q, widx_nx;
  logic [CW-1:0] acc_i_q, acc_u_q, acc_i_nx, acc_u_nx;
  logic [PW-1:0] n_and, n_or, n_xor;
  logic          first, last, ev_en, en_en;

  sig_word_pop #(.W(WORD_W), .PW(PW)) u_pop (
    .a(s_word), .b(ref_rdata), .n_and(n_and), .n_or(n_or), .n_xor(n_xor)
  );

  always_comb begin
    first     = (widx_q == '0);
    last      = (widx_q == XW'(N_WORDS - 1));
    ev_en     = s_valid && (sig_mode_e'(s_mode) == MODE_EVAL);
    en_en     = s_valid && (sig_mode_e'(s_mode) == MODE_ENROLL);
    widx_nx   = last ? '0 : widx_q + XW'(1);
    acc_i_nx  = (first ? '0 : acc_i_q) + CW'(n_and);
    acc_u_nx  = (first ? '0 : acc_u_q) + CW'(n_or);
    ref_wr    = en_en && (s_trial == '0);
    ref_addr  = {s_group, widx_q};
    ref_wdata = s_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0; acc_i_q <= '0; acc_u_q <= '0;
    end else begin
      if (s_valid) widx_q <= widx_nx;
      if (ev_en) begin
        acc_i_q <= acc_i_nx;
        acc_u_q <= acc_u_nx;
      end
    end
  end

  sig_frac_div #(.CW(CW), .FW(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(ev_en && last),
    .num(acc_i_nx), .den(acc_u_nx),
    .res_valid(jac_valid), .res_ratio(jac_ratio),
    .res_num(jac_inter), .res_den(jac_union), .res_empty(jac_empty)
  );

  sig_flip_select #(.NG(N_GROUPS), .NT(N_TRIALS), .FLW(FLW), .PW(PW),
                    .GW(GW), .TW(TW)) u_sel (
    .clk(clk), .rst_n(rst_n), .en(en_en), .first(first), .last(last),
    .group(s_group), .trial(s_trial), .xpop(n_xor),
    .done_valid(done_valid), .done_group(done_group), .done_flips(done_flips),
    .sel_valid(sel_valid), .sel_group(sel_group), .sel_flips(sel_flips)
  );
endmodule

// File: rtl/sig_eval_chk.sv
module sig_eval_chk #(
  parameter int FRAC_W = 16,
  parameter int CW = 17,
  parameter int FLW = 23,
  parameter int TW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           s_mode,
  input logic [TW-1:0]  s_trial,
  input logic           ref_wr,
  input logic           jac_valid,
  input logic [FRAC_W:0] jac_ratio,
  input logic [CW-1:0]  jac_inter,
  input logic [CW-1:0]  jac_union,
  input logic           jac_empty,
  input logic           done_valid,
  input logic [FLW-1:0] done_flips,
  input logic           sel_valid,
  input logic [FLW-1:0] sel_flips
);
  assert_empty_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jac_valid && jac_empty |-> jac_ratio == {1'b1, {FRAC_W{1'b0}}} && jac_union == '0);

  assert_inter_le_union_R2: assert property (@(posedge clk) disable iff (!rst_n)
    jac_valid |-> jac_inter <= jac_union);

  assert_ratio_below_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jac_valid && !jac_empty && jac_inter < jac_union |-> !jac_ratio[FRAC_W]);

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jac_valid |=> !jac_valid);

  assert_write_only_trial0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wr |-> s_valid && !s_mode && s_trial == '0);

  assert_best_not_worse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && sel_valid |-> sel_flips <= done_flips);

  assert_sel_rise_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_valid) |-> done_valid);
endmodule

bind sig_eval sig_eval_chk #(
  .FRAC_W(FRAC_W), .CW($clog2(SIG_BITS + 1)),
  .FLW($clog2(SIG_BITS * (N_TRIALS - 1) + 1)), .TW($clog2(N_TRIALS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_mode(s_mode),
  .s_trial(s_trial), .ref_wr(ref_wr), .jac_valid(jac_valid),
  .jac_ratio(jac_ratio), .jac_inter(jac_inter), .jac_union(jac_union),
  .jac_empty(jac_empty), .done_valid(done_valid), .done_flips(done_flips),
  .sel_valid(sel_valid), .sel_flips(sel_flips)
);

// File: tb/tb_sig_eval.sv
module tb_sig_eval;
  localparam int WW = 64, SB = 256, NT = 4, NG = 4, FR = 16;
  localparam int NW = SB / WW;
  localparam int GW = $clog2(NG), TW = $clog2(NT), XW = $clog2(NW);
  localparam int CW = $clog2(SB + 1), FLW = $clog2(SB * (NT - 1) + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_mode = 1'b0;
  logic [GW-1:0] s_group = '0;
  logic [TW-1:0] s_trial = '0;
  logic [WW-1:0] s_word = '0;
  logic ref_wr;
  logic [GW+XW-1:0] ref_addr;
  logic [WW-1:0] ref_wdata, ref_rdata;
  logic jac_valid, jac_empty, done_valid, sel_valid;
  logic [FR:0] jac_ratio;
  logic [CW-1:0] jac_inter, jac_union;
  logic [GW-1:0] done_group, sel_group;
  logic [FLW-1:0] done_flips, sel_flips;

  logic [WW-1:0] store [NG*NW];
  assign ref_rdata = store[ref_addr];

  always #2 clk = ~clk;

  sig_eval #(.WORD_W(WW), .SIG_BITS(SB), .N_TRIALS(NT), .N_GROUPS(NG), .FRAC_W(FR)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_mode(s_mode), .s_group(s_group),
    .s_trial(s_trial), .s_word(s_word), .ref_wr(ref_wr), .ref_addr(ref_addr),
    .ref_wdata(ref_wdata), .ref_rdata(ref_rdata), .jac_valid(jac_valid),
    .jac_ratio(jac_ratio), .jac_inter(jac_inter), .jac_union(jac_union),
    .jac_empty(jac_empty), .done_valid(done_valid), .done_group(done_group),
    .done_flips(done_flips), .sel_valid(sel_valid), .sel_group(sel_group),
    .sel_flips(sel_flips)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  typedef struct { int due; int i; int u; } pend_t;
  pend_t pq[$];
  int cyc = 0, m_widx = 0, ai = 0, au = 0;
  int flips [NG];
  bit e_jv = 0, e_je = 0, e_dv = 0, e_sv = 0;
  longint e_jr = 0;
  int e_ji = 0, e_ju = 0, e_dg = 0, e_df = 0, e_sg = 0, e_sf = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      int a; logic [WW-1:0] gd; pend_t p;
      cyc++;
      e_jv = 0; e_dv = 0;
      if (pq.size() > 0 && pq[0].due == cyc) begin
        p = pq.pop_front();
        e_jv = 1; e_ji = p.i; e_ju = p.u; e_je = (p.u == 0);
        e_jr = (p.u == 0) ? (longint'(1) << FR) : (longint'(p.i) << FR) / p.u;
      end
      if (s_valid) begin
        a = int'(s_group) * NW + m_widx;
        gd = store[a];
        if (s_mode) begin
          if (m_widx == 0) begin ai = 0; au = 0; end
          ai += $countones(s_word & gd);
          au += $countones(s_word | gd);
          if (m_widx == NW - 1) pq.push_back('{cyc + FR, ai, au});
        end else begin
          if (s_trial == 0) begin
            store[a] <= s_word;
            if (m_widx == 0) begin
              flips[s_group] = 0;
              if (s_group == 0) e_sv = 0;
            end
          end else flips[s_group] += $countones(s_word ^ gd);
          if (m_widx == NW - 1 && s_trial == NT - 1) begin
            e_dv = 1; e_dg = s_group; e_df = flips[s_group];
            if (!e_sv || flips[s_group] < e_sf) begin
              e_sv = 1; e_sg = s_group; e_sf = flips[s_group];
            end
          end
        end
        m_widx = (m_widx + 1) % NW;
      end
    end
  end

  int ncyc = 0;
  bit fin = 0;
  always @(negedge clk) begin
    ncyc++;
    if (!rst_n) begin
      chk("R1 jac_valid", jac_valid, 0);
      chk("R1 done_valid", done_valid, 0);
      chk("R1 sel_valid", sel_valid, 0);
      chk("R1 jac_ratio", jac_ratio, 0);
      chk("R1 jac_inter", jac_inter, 0);
      chk("R1 jac_union", jac_union, 0);
    end else if (!fin) begin
      chk("R4 jac_valid", jac_valid, e_jv);
      chk("R2 R10 jac_inter", jac_inter, e_ji);
      chk("R3 R10 jac_union", jac_union, e_ju);
      chk("R4 R10 jac_ratio", jac_ratio, e_jr);
      chk("R5 jac_empty", jac_empty, e_je);
      chk("R7 done_valid", done_valid, e_dv);
      if (e_dv) begin
        chk("R7 done_group", done_group, e_dg);
        chk("R7 R9 done_flips", done_flips, e_df);
      end
      chk("R8 R11 sel_valid", sel_valid, e_sv);
      if (e_sv) begin
        chk("R8 sel_group", sel_group, e_sg);
        chk("R8 sel_flips", sel_flips, e_sf);
      end
      chk("R6 ref_wr", ref_wr, s_valid && !s_mode && s_trial == 0);
      if (s_valid) chk("R6 ref_addr", ref_addr, int'(s_group) * NW + m_widx);
      if (ref_wr) chk("R6 ref_wdata", ref_wdata, s_word);
    end
    if (ncyc > 20000 && !fin) begin
      fin = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", ncyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic put(input bit md, input int g, input int t, input logic [WW-1:0] w);
    @(posedge clk); #1;
    s_valid = 1'b1; s_mode = md; s_group = g[GW-1:0]; s_trial = t[TW-1:0]; s_word = w;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; s_valid = 1'b0; end
  endtask
  function automatic logic [WW-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  logic [WW-1:0] base [NG][NW];

  task automatic enroll(input int g, input bit noisy);
    for (int t = 0; t < NT; t++)
      for (int w = 0; w < NW; w++)
        put(0, g, t, (t > 0 && noisy) ? base[g][w] ^ (rnd() & rnd() & rnd()) : base[g][w]);
  endtask
  task automatic evaluate(input int g, input int kind);
    for (int w = 0; w < NW; w++) begin
      logic [WW-1:0] gw;
      gw = store[g * NW + w];
      case (kind)
        0: put(1, g, 0, gw);
        1: put(1, g, 0, rnd());
        2: put(1, g, 0, '0);
        3: put(1, g, 0, ~gw);
        default: put(1, g, 0, gw & rnd());
      endcase
      if (w == 1) idle(2);
    end
    idle(FR + 4);
  endtask

  initial begin
    for (int i = 0; i < NG * NW; i++) store[i] = '0;
    for (int g = 0; g < NG; g++) begin
      flips[g] = 0;
      for (int w = 0; w < NW; w++) base[g][w] = (g == 3) ? '0 : rnd();
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    enroll(0, 1);   // R7 noisy group
    enroll(1, 0);   // R8 zero flips
    enroll(2, 1);
    enroll(3, 0);   // R8 tie with group 1 kept out
    idle(3);
    enroll(2, 0);   // R9 re-enroll restarts total
    idle(3);
    enroll(0, 0);   // R11 restart of selection
    idle(3);
    evaluate(0, 0); // R4 identical -> 1.0
    evaluate(1, 1); // R2 R3 random
    evaluate(3, 2); // R5 empty union
    evaluate(2, 3); // R4 disjoint -> 0
    evaluate(1, 4); // R2 subset
    evaluate(0, 1);
    enroll(1, 1);   // R10 enrollment leaves Jaccard outputs
    idle(5);
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule